// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block decides whether a conditional branch or a conditionally executed instruction should take effect. It takes a 4-bit condition selector and the four arithmetic flags: negative, zero, carry and overflow. It reports on one combinational output whether the selected condition holds for the flags it sees in that cycle.

The flags come in on input ports from whatever unit keeps them. The block does not compute them. When the instruction stream marks a valid branch in the same cycle and its condition holds, the block raises a registered taken strobe on the next clock edge. Decoding the instruction and computing the branch target are left to the neighbouring units.

The selector codes come in complementary pairs. An even code tests a flag term and the odd code that follows tests its inverse. The unsigned comparisons are built from carry and zero. The signed comparisons are built from the agreement of negative and overflow, together with zero. The two highest codes always pass.

Top module: `cond_eval_unit`

## Requirements
- R1: Code 0 (equal) passes exactly when Z=1, and code 1 (not equal) passes exactly when Z=0.
- R2: Code 2 (carry set, unsigned higher or same) passes exactly when C=1, and code 3 (carry clear, unsigned lower) passes exactly when C=0.
- R3: Code 4 (minus) passes exactly when N=1, and code 5 (plus or zero) passes exactly when N=0.
- R4: Code 6 (overflow) passes exactly when V=1, and code 7 (no overflow) passes exactly when V=0.
- R5: Code 8 (unsigned higher) passes exactly when C=1 and Z=0. Code 9 (unsigned lower or same) passes exactly when C=0 or Z=1.
- R6: Code 10 (signed greater or equal) passes exactly when N equals V, and code 11 (signed less than) passes exactly when N differs from V.
- R7: Code 12 (signed greater than) passes exactly when Z=0 and N equals V. Code 13 (signed less or equal) passes exactly when Z=1 or N differs from V.
- R8: Codes 14 and 15 pass for every flag combination.
- R9: `cond_pass_o` follows the selector and flags in the same cycle and does not depend on `br_valid_i`.
- R10: `br_taken_o` is high in the cycle after a cycle in which `br_valid_i` is high and the condition passes. It is high for one cycle per such valid cycle, and low after any cycle with `br_valid_i` low or a failing condition.
- R11: `br_taken_o` is low while reset is asserted and in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 4 | Condition selector, codes 0 to 15 |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| br_valid_i | input | 1 | A branch is presented this cycle |
| cond_pass_o | output | 1 | Selected condition holds (combinational) |
| br_taken_o | output | 1 | Registered one-cycle taken strobe |

## Verification
The only stored state is the taken strobe, so a fault there shows on `br_taken_o` one edge after the branch that caused it. The fault shows either as a stuck strobe, a strobe that stretches past one cycle, or a strobe after a failing or invalid cycle. A wrong entry in the pass table has no delay. It shows on `cond_pass_o` in the same cycle for the affected code and flag pattern. The sweep covers every code against all sixteen flag patterns, so each table entry is seen at least once in both polarities. Back-to-back valid cycles and valid cycles with a failing condition show whether the strobe is gated and cleared at the right edge.

// File: rtl/cev_pkg.sv
package cev_pkg;

    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int NUM_PAIRS = 7;
    localparam int FIRST_AL  = 2 * NUM_PAIRS;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic taken;
    } cev_state_t;

endpackage

// File: rtl/cev_flag_terms.sv
// Computes the base term of each complementary condition pair.
module cev_flag_terms
    import cev_pkg::*;
(
    input  flags_t               flags_i,
    output logic [NUM_PAIRS-1:0] base_o
);

    logic sign_agree;

    always_comb begin
        sign_agree = (flags_i.n == flags_i.v);
        base_o[0]  = flags_i.z;                       // equal
        base_o[1]  = flags_i.c;                       // carry set
        base_o[2]  = flags_i.n;                       // minus
        base_o[3]  = flags_i.v;                       // overflow
        base_o[4]  = flags_i.c & ~flags_i.z;          // unsigned higher
        base_o[5]  = sign_agree;                      // signed ge
        base_o[6]  = ~flags_i.z & sign_agree;         // signed gt
    end

endmodule

// File: rtl/cev_pass_table.sv
// Expands the pair terms into one pass bit per selector code.
module cev_pass_table
    import cev_pkg::*;
(
    input  logic [NUM_PAIRS-1:0] base_i,
    output logic [NUM_CODES-1:0] pass_vec_o
);

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        assign pass_vec_o[2*k]   =  base_i[k];
        assign pass_vec_o[2*k+1] = ~base_i[k];
    end

    for (genvar a = FIRST_AL; a < NUM_CODES; a++) begin : g_always
        assign pass_vec_o[a] = 1'b1;
    end

endmodule

// File: rtl/cev_cond_mux.sv
// Picks the pass bit named by the selector.
module cev_cond_mux
    import cev_pkg::*;
(
    input  logic [NUM_CODES-1:0] pass_vec_i,
    input  logic [CODE_W-1:0]    cond_i,
    output logic                 pass_o
);

    always_comb begin
        pass_o = pass_vec_i[cond_i];
    end

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
    import cev_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] cond_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic              flag_v_i,
    input  logic              br_valid_i,
    output logic              cond_pass_o,
    output logic              br_taken_o
);

    flags_t               flags;
    logic [NUM_PAIRS-1:0] base;
    logic [NUM_CODES-1:0] pass_vec;
    logic                 pass;
    cev_state_t           state_d;
    cev_state_t           state_q;

    assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

    cev_flag_terms u_terms (
        .flags_i (flags),
        .base_o  (base)
    );

    cev_pass_table u_table (
        .base_i     (base),
        .pass_vec_o (pass_vec)
    );

    cev_cond_mux u_mux (
        .pass_vec_i (pass_vec),
        .cond_i     (cond_i),
        .pass_o     (pass)
    );

    always_comb begin
        state_d       = state_q;
        state_d.taken = br_valid_i & pass;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cond_pass_o = pass;
    assign br_taken_o  = state_q.taken;

endmodule

// File: rtl/cev_checker.sv
module cev_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [3:0] cond_i,
    input logic       flag_n_i,
    input logic       flag_z_i,
    input logic       flag_c_i,
    input logic       flag_v_i,
    input logic       br_valid_i,
    input logic       cond_pass_o,
    input logic       br_taken_o
);

    AST_EQ_FOLLOWS_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == 4'd0) |-> (cond_pass_o == flag_z_i)); // R1

    AST_CC_INVERTS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == 4'd3) |-> (cond_pass_o != flag_c_i)); // R2

    AST_HI_NEEDS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == 4'd8 && cond_pass_o) |-> (flag_c_i && !flag_z_i)); // R5

    AST_LT_SIGN_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == 4'd11) |-> (cond_pass_o == (flag_n_i ^ flag_v_i))); // R6

    AST_LE_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == 4'd13 && flag_z_i) |-> cond_pass_o); // R7

    AST_ALWAYS_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i[3:1] == 3'b111) |-> cond_pass_o); // R8

    AST_TAKEN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (br_valid_i && cond_pass_o) |=> br_taken_o); // R10

    AST_NO_TAKE_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(br_valid_i && cond_pass_o) |=> !br_taken_o); // R10

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            AST_RESET_QUIET: assert (!br_taken_o); // R11
        end
    end

endmodule

bind cond_eval_unit cev_checker u_cev_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cond_i      (cond_i),
    .flag_n_i    (flag_n_i),
    .flag_z_i    (flag_z_i),
    .flag_c_i    (flag_c_i),
    .flag_v_i    (flag_v_i),
    .br_valid_i  (br_valid_i),
    .cond_pass_o (cond_pass_o),
    .br_taken_o  (br_taken_o)
);

// File: tb/cond_eval_unit_tb_top.sv
`timescale 1ns/100ps
module cond_eval_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond = '0;
    logic       fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
    logic       valid = 1'b0;
    logic       pass_o;
    logic       taken_o;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        logic  taken;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    cond_eval_unit dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cond_i      (cond),
        .flag_n_i    (fn),
        .flag_z_i    (fz),
        .flag_c_i    (fc),
        .flag_v_i    (fv),
        .br_valid_i  (valid),
        .cond_pass_o (pass_o),
        .br_taken_o  (taken_o)
    );

    function automatic logic model_pass(logic [3:0] c, logic n, logic z, logic cy, logic v);
        case (c)
            4'd0:    return z;
            4'd1:    return !z;
            4'd2:    return cy;
            4'd3:    return !cy;
            4'd4:    return n;
            4'd5:    return !n;
            4'd6:    return v;
            4'd7:    return !v;
            4'd8:    return cy && !z;
            4'd9:    return !cy || z;
            4'd10:   return n == v;
            4'd11:   return n != v;
            4'd12:   return !z && (n == v);
            4'd13:   return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string code_tag(logic [3:0] c);
        case (c)
            4'd0, 4'd1:   return "R1";
            4'd2, 4'd3:   return "R2";
            4'd4, 4'd5:   return "R3";
            4'd6, 4'd7:   return "R4";
            4'd8, 4'd9:   return "R5";
            4'd10, 4'd11: return "R6";
            4'd12, 4'd13: return "R7";
            default:      return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (cond=%0d nzcv=%b%b%b%b valid=%b)",
                     tag, act, exp, cond, fn, fz, fc, fv, valid);
        end
    endtask

    // Driver: one branch slot per cycle, pushes the expected strobe.
    task automatic drive(logic [3:0] c, logic [3:0] nzcv, logic vld, string tag);
        logic exp_pass;
        @(posedge clk);
        #0.5;
        cond  = c;
        {fn, fz, fc, fv} = nzcv;
        valid = vld;
        #0.5;
        exp_pass = model_pass(c, nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
        check(tag, pass_o, exp_pass);
        sb_q.push_back('{taken: vld && exp_pass, tag: "R10"});
    endtask

    // Monitor: compares the strobe one edge after the item was pushed.
    initial begin
        forever begin
            @(posedge clk);
            #0.3;
            if (mon_on && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, taken_o, e.taken);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: strobe low during reset, even with a passing valid branch.
        cond  = 4'd14;
        valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R11", taken_o, 1'b0);
        valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R11", taken_o, 1'b0);
        mon_on = 1'b1;

        // Exhaustive sweep: every code against every flag pattern.
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                drive(4'(c), 4'(f), ((c + f) % 3) != 0, code_tag(4'(c)));
            end
        end

        // R10: back-to-back valid passing branches give one strobe each.
        drive(4'd14, 4'b0000, 1'b1, "R10");
        drive(4'd0,  4'b0100, 1'b1, "R10");
        drive(4'd0,  4'b0000, 1'b1, "R10");
        drive(4'd15, 4'b1111, 1'b0, "R10");

        // R9: pass output unaffected by valid, same code and flags.
        drive(4'd12, 4'b0000, 1'b0, "R9");
        drive(4'd12, 4'b0000, 1'b1, "R9");
        drive(4'd13, 4'b1000, 1'b0, "R9");
        drive(4'd13, 4'b1000, 1'b1, "R9");
        drive(4'd9,  4'b0000, 1'b0, "R9");

        repeat (2) @(posedge clk);
        #1;
        finish_run();
    end

endmodule